// File: doc/BRIEF.md
# PCI target command filter

This block watches a 32-bit multiplexed address/data bus from the target side and follows each transaction from its address phase to its final data phase. When a transaction starts, it captures the bus command and the start address and reports them, with the command sorted into a compact class code. It then walks the data phases. A phase counts only on a clock where both the initiator-ready and the target-ready handshakes are active. Each completed phase is reported as accepted or dropped, along with the address it belongs to.

A phase is accepted only when the command is one the filter claims and all four byte lanes are enabled. Any other completed phase still finishes on the bus, but its data never reaches the accepted-data output. A per-transaction flag records that the filter ignored something. Downstream logic uses the accept strobe as a clean write/read-data event stream. It uses the flag to learn that part of a transaction was discarded.

Top module: `pci_tgt_cmd_filter`

## Requirements
- R1: After reset every strobe (`addr_vld_o`, `beat_acc_o`, `beat_drop_o`, `beat_last_o`) is low. `cmd_kind_o`, `reserved_o`, `xact_ign_o`, `addr_o`, `beat_addr_o` and `beat_data_o` are all zero.
- R2: While idle, a clock with `frame_n` low is an address phase. One clock later `addr_vld_o` is high for exactly one cycle and `addr_o` holds the value of `ad_i` from that clock.
- R3: The command on `cbe_n_i[3:0]` in the address phase is reported on `cmd_kind_o` from the next clock until the next address phase. The mapping is 0000→1, 0001→2, 0110→3, 0111→4, 1010→5, 1011→6, 1100→7, 1101→8, 1110→9, 1111→10.
- R4: Commands 0010, 0011, 0100, 0101, 1000 and 1001 are reserved. They give `cmd_kind_o`=15 and `reserved_o`=1, and none of their data phases is accepted.
- R5: A data phase completes only on a clock where `irdy_n` and `trdy_n` are both low. Any other clock produces no accept or drop strobe and leaves `beat_addr_o` unchanged.
- R6: A completed phase of a claimed command with `cbe_n_i`=0000 pulses `beat_acc_o` one clock later. On that clock `beat_data_o` equals that phase's `ad_i`.
- R7: A completed phase with any `cbe_n_i` bit high, or belonging to a reserved command, pulses `beat_drop_o` instead of `beat_acc_o` and leaves `beat_data_o` unchanged. Later phases of the same transaction are still processed.
- R8: `beat_addr_o` of the first completed phase equals the latched address. Each later completed phase adds 4, modulo 2^32, whether it was accepted or dropped.
- R9: A completed phase on a clock with `frame_n` high is the final one. `beat_last_o` pulses alongside its accept or drop strobe, the filter returns to idle, and the very next clock may start a new address phase.
- R10: `xact_ign_o` is set in the address phase exactly when the command is reserved. It is set by any dropped phase and holds until the next address phase.
- R11: Reset in the middle of a transaction returns the filter to idle. Afterwards, handshake clocks with `frame_n` high produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low transaction frame |
| irdy_n | input | 1 | Active-low initiator ready |
| trdy_n | input | 1 | Active-low target ready |
| ad_i | input | DW (32) | Multiplexed address/data |
| cbe_n_i | input | DW/8 (4) | Command in address phase, active-low lane enables in data phases |
| addr_vld_o | output | 1 | One-cycle pulse after an address phase |
| addr_o | output | AW (32) | Latched start address |
| cmd_kind_o | output | 4 | Command class code |
| reserved_o | output | 1 | Current command is reserved and unclaimed |
| beat_acc_o | output | 1 | Completed phase accepted |
| beat_drop_o | output | 1 | Completed phase discarded |
| beat_last_o | output | 1 | Completed phase was the final one |
| beat_addr_o | output | AW (32) | Address of the latest completed phase |
| beat_data_o | output | DW (32) | Data of the latest accepted phase |
| xact_ign_o | output | 1 | Current transaction had something ignored |

## Verification
The bench sweeps every one of the sixteen command codes. A decoder that misclassifies a code shows the wrong class, and a filter that claims a reserved code emits accept strobes that should not exist. Partial lane masks placed at different beat positions catch a filter that drops data silently but stops processing the burst, or that overwrites the accepted data with discarded bytes. Wait-state clocks, an address that wraps past the top of the space, and a new address phase right after a final phase catch three faults: an address counter that advances without a handshake, one that saturates instead of wrapping, and a state machine that needs an idle clock between transactions. A reset in mid-burst, followed by handshakes with the frame inactive, catches state left over from the interrupted transaction.

// File: rtl/pci_tf_pkg.sv
package pci_tf_pkg;

   typedef enum logic [3:0] {
      KIND_NONE   = 4'd0,
      KIND_INTA   = 4'd1,
      KIND_SPEC   = 4'd2,
      KIND_MRD    = 4'd3,
      KIND_MWR    = 4'd4,
      KIND_CRD    = 4'd5,
      KIND_CWR    = 4'd6,
      KIND_MRDM   = 4'd7,
      KIND_DUAL   = 4'd8,
      KIND_MRDL   = 4'd9,
      KIND_MWRI   = 4'd10,
      KIND_RSVD   = 4'd15
   } cmd_kind_e;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_DATA = 1'b1
   } tf_state_e;

endpackage

// File: rtl/pci_tf_cmd_dec.sv
module pci_tf_cmd_dec
   import pci_tf_pkg::*;
#(
   parameter int CMD_W = 4
) (
   input  logic [CMD_W-1:0] cmd_i,
   output cmd_kind_e        kind_o,
   output logic             rsvd_o
);

   always_comb begin
      kind_o = KIND_RSVD;
      case (cmd_i)
         4'b0000: kind_o = KIND_INTA;
         4'b0001: kind_o = KIND_SPEC;
         4'b0110: kind_o = KIND_MRD;
         4'b0111: kind_o = KIND_MWR;
         4'b1010: kind_o = KIND_CRD;
         4'b1011: kind_o = KIND_CWR;
         4'b1100: kind_o = KIND_MRDM;
         4'b1101: kind_o = KIND_DUAL;
         4'b1110: kind_o = KIND_MRDL;
         4'b1111: kind_o = KIND_MWRI;
         default: kind_o = KIND_RSVD;
      endcase
      rsvd_o = (kind_o == KIND_RSVD);
   end

endmodule

// File: rtl/pci_tf_lane_chk.sv
module pci_tf_lane_chk #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] be_n_i,
   output logic             all_on_o
);

   generate
      if (LANES == 1) begin : g_single
         assign all_on_o = ~be_n_i[0];
      end else begin : g_multi
         logic [LANES-1:0] lane_on;
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_on[k] = ~be_n_i[k];
         end
         assign all_on_o = &lane_on;
      end
   endgenerate

endmodule

// File: rtl/pci_tf_addr_ctr.sv
module pci_tf_addr_ctr #(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          adv_i,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW-1:0] INC = AW'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o <= '0;
      end else if (load_i) begin
         addr_o <= load_val_i;
      end else if (adv_i) begin
         addr_o <= addr_o + INC;
      end
   end

endmodule

// File: rtl/pci_tgt_cmd_filter.sv
module pci_tgt_cmd_filter
   import pci_tf_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CMD_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_n,
   input  logic            irdy_n,
   input  logic            trdy_n,
   input  logic [DW-1:0]   ad_i,
   input  logic [DW/8-1:0] cbe_n_i,
   output logic            addr_vld_o,
   output logic [AW-1:0]   addr_o,
   output logic [3:0]      cmd_kind_o,
   output logic            reserved_o,
   output logic            beat_acc_o,
   output logic            beat_drop_o,
   output logic            beat_last_o,
   output logic [AW-1:0]   beat_addr_o,
   output logic [DW-1:0]   beat_data_o,
   output logic            xact_ign_o
);

   localparam int LANES = DW / 8;
   localparam int STEP  = LANES;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("pci_tgt_cmd_filter: DW must be a positive multiple of 8");
      end
      if (CMD_W != 4) begin : g_bad_cmd
         $error("pci_tgt_cmd_filter: CMD_W must be 4");
      end
      if (LANES < CMD_W) begin : g_bad_lanes
         $error("pci_tgt_cmd_filter: too few lane enables to carry a command");
      end
      if (AW > DW || AW < 2) begin : g_bad_aw
         $error("pci_tgt_cmd_filter: AW must fit on the data lines");
      end
   endgenerate

   tf_state_e        state_q;
   cmd_kind_e        kind_d;
   cmd_kind_e        kind_q;
   logic             rsvd_d;
   logic             rsvd_q;
   logic             lanes_full;
   logic             addr_phase;
   logic             beat_done;
   logic             beat_take;
   logic [AW-1:0]    cur_addr;

   pci_tf_cmd_dec #(.CMD_W(CMD_W)) u_dec (
      .cmd_i  (cbe_n_i[CMD_W-1:0]),
      .kind_o (kind_d),
      .rsvd_o (rsvd_d)
   );

   pci_tf_lane_chk #(.LANES(LANES)) u_lanes (
      .be_n_i   (cbe_n_i),
      .all_on_o (lanes_full)
   );

   assign addr_phase = (state_q == ST_IDLE) && !frame_n;
   assign beat_done  = (state_q == ST_DATA) && !irdy_n && !trdy_n;
   assign beat_take  = beat_done && !rsvd_q && lanes_full;

   pci_tf_addr_ctr #(.AW(AW), .STEP(STEP)) u_actr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (addr_phase),
      .load_val_i (ad_i[AW-1:0]),
      .adv_i      (beat_done),
      .addr_o     (cur_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (addr_phase) state_q <= ST_DATA;
            ST_DATA: if (beat_done && frame_n) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_vld_o  <= 1'b0;
         beat_acc_o  <= 1'b0;
         beat_drop_o <= 1'b0;
         beat_last_o <= 1'b0;
      end else begin
         addr_vld_o  <= addr_phase;
         beat_acc_o  <= beat_take;
         beat_drop_o <= beat_done && !beat_take;
         beat_last_o <= beat_done && frame_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o     <= '0;
         kind_q     <= KIND_NONE;
         rsvd_q     <= 1'b0;
         xact_ign_o <= 1'b0;
      end else if (addr_phase) begin
         addr_o     <= ad_i[AW-1:0];
         kind_q     <= kind_d;
         rsvd_q     <= rsvd_d;
         xact_ign_o <= rsvd_d;
      end else if (beat_done && !beat_take) begin
         xact_ign_o <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_addr_o <= '0;
         beat_data_o <= '0;
      end else begin
         if (beat_done) beat_addr_o <= cur_addr;
         if (beat_take) beat_data_o <= ad_i;
      end
   end

   assign cmd_kind_o = kind_q;
   assign reserved_o = rsvd_q;

endmodule

// File: rtl/pci_tf_chk.sv
module pci_tf_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            frame_n,
   input logic            irdy_n,
   input logic            trdy_n,
   input logic [DW/8-1:0] cbe_n_i,
   input logic            addr_vld_o,
   input logic [AW-1:0]   addr_o,
   input logic            reserved_o,
   input logic            beat_acc_o,
   input logic            beat_drop_o,
   input logic            beat_last_o,
   input logic [AW-1:0]   beat_addr_o,
   input logic [DW-1:0]   beat_data_o,
   input logic            xact_ign_o
);

   localparam logic [AW-1:0] INC = AW'(DW / 8);

   logic          beat;
   logic [AW-1:0] exp_addr_q;

   assign beat = beat_acc_o || beat_drop_o;

   always_ff @(posedge clk) begin
      if (!rst_n)          exp_addr_q <= '0;
      else if (addr_vld_o) exp_addr_q <= addr_o;
      else if (beat)       exp_addr_q <= beat_addr_o + INC;
   end

   p_vld_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld_o |-> $past(!frame_n));

   p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld_o |=> !addr_vld_o);

   p_rsvd_no_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_o |-> !beat_acc_o);

   p_beat_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> $past(!irdy_n && !trdy_n));

   p_acc_full_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      beat_acc_o |-> ($past(cbe_n_i) == '0));

   p_acc_drop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(beat_acc_o && beat_drop_o));

   p_drop_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      beat_drop_o |-> $stable(beat_data_o));

   p_beat_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (beat_addr_o == exp_addr_q));

   p_last_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last_o |-> (beat && $past(frame_n)));

   p_drop_sets_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
      beat_drop_o |-> xact_ign_o);

endmodule

bind pci_tgt_cmd_filter pci_tf_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_n     (frame_n),
   .irdy_n      (irdy_n),
   .trdy_n      (trdy_n),
   .cbe_n_i     (cbe_n_i),
   .addr_vld_o  (addr_vld_o),
   .addr_o      (addr_o),
   .reserved_o  (reserved_o),
   .beat_acc_o  (beat_acc_o),
   .beat_drop_o (beat_drop_o),
   .beat_last_o (beat_last_o),
   .beat_addr_o (beat_addr_o),
   .beat_data_o (beat_data_o),
   .xact_ign_o  (xact_ign_o)
);

// File: tb/pci_tgt_cmd_filter_bench.sv
module pci_tgt_cmd_filter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        irdy_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;

   logic        addr_vld_o, reserved_o, beat_acc_o, beat_drop_o, beat_last_o, xact_ign_o;
   logic [31:0] addr_o, beat_addr_o, beat_data_o;
   logic [3:0]  cmd_kind_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] last_data = '0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pci_tgt_cmd_filter u_pci_tgt_cmd_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_n     (frame_n),
      .irdy_n      (irdy_n),
      .trdy_n      (trdy_n),
      .ad_i        (ad),
      .cbe_n_i     (cbe_n),
      .addr_vld_o  (addr_vld_o),
      .addr_o      (addr_o),
      .cmd_kind_o  (cmd_kind_o),
      .reserved_o  (reserved_o),
      .beat_acc_o  (beat_acc_o),
      .beat_drop_o (beat_drop_o),
      .beat_last_o (beat_last_o),
      .beat_addr_o (beat_addr_o),
      .beat_data_o (beat_data_o),
      .xact_ign_o  (xact_ign_o)
   );

   // row: {cmd[3:0], addr[31:0], beats[2:0], drop_mask[3:0], kind[3:0]}
   localparam logic [46:0] TBL [0:15] = '{
      {4'h0, 32'h0000_1000, 3'd1, 4'b0000, 4'd1},
      {4'h1, 32'h0000_2000, 3'd1, 4'b0000, 4'd2},
      {4'h2, 32'h0000_3000, 3'd2, 4'b0000, 4'd15},
      {4'h3, 32'h0000_3100, 3'd1, 4'b0000, 4'd15},
      {4'h4, 32'h0000_3200, 3'd1, 4'b0000, 4'd15},
      {4'h5, 32'h0000_3300, 3'd1, 4'b0000, 4'd15},
      {4'h6, 32'h1000_0000, 3'd4, 4'b0000, 4'd3},
      {4'h7, 32'h1000_0100, 3'd4, 4'b0101, 4'd4},
      {4'h8, 32'h2000_0000, 3'd1, 4'b0000, 4'd15},
      {4'h9, 32'h2000_0010, 3'd1, 4'b0000, 4'd15},
      {4'hA, 32'h0000_0800, 3'd2, 4'b0000, 4'd5},
      {4'hB, 32'h0000_0804, 3'd3, 4'b0010, 4'd6},
      {4'hC, 32'h3000_0000, 3'd3, 4'b0000, 4'd7},
      {4'hD, 32'h3000_1000, 3'd1, 4'b0001, 4'd8},
      {4'hE, 32'hFFFF_FFF8, 3'd3, 4'b0000, 4'd9},
      {4'hF, 32'h4000_0040, 3'd4, 4'b1000, 4'd10}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic f, input logic i, input logic t,
                        input logic [3:0] c, input logic [31:0] d);
      frame_n = f; irdy_n = i; trdy_n = t; cbe_n = c; ad = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_cycle();
      drive(1'b1, 1'b1, 1'b1, 4'h0, 32'h0);
   endtask

   task automatic run_xact(input logic [3:0] cmd, input logic [31:0] addr,
                           input int beats, input logic [3:0] mask,
                           input logic [3:0] kind);
      logic rsvd;
      logic ign;
      rsvd = (kind == 4'd15);
      drive(1'b0, 1'b1, 1'b1, cmd, addr);
      chk("R2", "addr_vld", 32'(addr_vld_o), 32'd1);
      chk("R2", "addr", addr_o, addr);
      chk("R3", "kind", 32'(cmd_kind_o), 32'(kind));
      chk("R4", "reserved", 32'(reserved_o), 32'(rsvd));
      chk("R10", "ign at addr phase", 32'(xact_ign_o), 32'(rsvd));
      ign = rsvd;
      for (int i = 0; i < beats; i++) begin
         logic        dropit;
         logic [3:0]  cb;
         logic [31:0] dat;
         dropit = rsvd || mask[i];
         cb     = mask[i] ? (4'b0001 << i) : 4'b0000;
         dat    = (addr ^ 32'h5A5A_0000) + 32'(i * 17 + 1);
         drive((i == beats - 1), 1'b0, 1'b0, cb, dat);
         chk("R6", "beat_acc", 32'(beat_acc_o), 32'(!dropit));
         chk("R7", "beat_drop", 32'(beat_drop_o), 32'(dropit));
         chk("R8", "beat_addr", beat_addr_o, addr + 32'(4 * i));
         chk("R9", "beat_last", 32'(beat_last_o), 32'(i == beats - 1));
         if (!dropit) last_data = dat;
         chk(dropit ? "R7" : "R6", "beat_data", beat_data_o, last_data);
         ign = ign | dropit;
         chk("R10", "xact_ign", 32'(xact_ign_o), 32'(ign));
      end
      idle_cycle();
      chk("R9", "idle no beat", 32'({beat_acc_o, beat_drop_o, addr_vld_o}), 32'd0);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "strobes", 32'({addr_vld_o, beat_acc_o, beat_drop_o, beat_last_o}), 32'd0);
      chk("R1", "kind", 32'(cmd_kind_o), 32'd0);
      chk("R1", "flags", 32'({reserved_o, xact_ign_o}), 32'd0);
      chk("R1", "addr", addr_o | beat_addr_o, 32'd0);
      chk("R1", "data", beat_data_o, 32'd0);

      // table of transactions over every command code
      for (int r = 0; r < 16; r++) begin
         run_xact(TBL[r][46:43], TBL[r][42:11], int'(TBL[r][10:8]),
                  TBL[r][7:4], TBL[r][3:0]);
      end

      // R5: wait states inside a burst
      drive(1'b0, 1'b1, 1'b1, 4'h7, 32'h0000_0050);
      chk("R2", "addr_vld ws", 32'(addr_vld_o), 32'd1);
      drive(1'b0, 1'b0, 1'b0, 4'h0, 32'hCAFE_0001);
      chk("R6", "ws beat0 acc", 32'(beat_acc_o), 32'd1);
      last_data = 32'hCAFE_0001;
      drive(1'b0, 1'b0, 1'b1, 4'h0, 32'hDEAD_0000);
      chk("R5", "trdy wait no strobe", 32'({beat_acc_o, beat_drop_o}), 32'd0);
      chk("R5", "trdy wait addr held", beat_addr_o, 32'h0000_0050);
      drive(1'b0, 1'b1, 1'b0, 4'h0, 32'hDEAD_0001);
      chk("R5", "irdy wait no strobe", 32'({beat_acc_o, beat_drop_o}), 32'd0);
      chk("R5", "data unchanged in wait", beat_data_o, last_data);
      drive(1'b1, 1'b0, 1'b0, 4'h0, 32'hCAFE_0002);
      chk("R8", "ws beat1 addr", beat_addr_o, 32'h0000_0054);
      chk("R9", "ws beat1 last", 32'({beat_acc_o, beat_last_o}), 32'd3);
      last_data = 32'hCAFE_0002;

      // R9: back-to-back address phase right after the final phase
      drive(1'b0, 1'b1, 1'b1, 4'h6, 32'h0000_0600);
      chk("R9", "back-to-back addr_vld", 32'(addr_vld_o), 32'd1);
      chk("R9", "back-to-back addr", addr_o, 32'h0000_0600);
      chk("R10", "ign cleared", 32'(xact_ign_o), 32'd0);
      drive(1'b1, 1'b0, 1'b0, 4'h0, 32'h1234_5678);
      chk("R6", "b2b accept data", beat_data_o, 32'h1234_5678);
      last_data = 32'h1234_5678;
      idle_cycle();

      // R11: reset in mid-burst
      drive(1'b0, 1'b1, 1'b1, 4'h7, 32'h0000_0900);
      drive(1'b0, 1'b0, 1'b0, 4'h0, 32'h0BAD_0BAD);
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 4'h0, 32'h0BAD_0BAE);
      rst_n = 1'b1;
      last_data = '0;
      chk("R1", "mid-reset strobes", 32'({addr_vld_o, beat_acc_o, beat_drop_o}), 32'd0);
      chk("R1", "mid-reset data", beat_data_o, 32'd0);
      drive(1'b1, 1'b0, 1'b0, 4'h0, 32'h7777_7777);
      chk("R11", "no strobe after reset", 32'({addr_vld_o, beat_acc_o, beat_drop_o, beat_last_o}), 32'd0);
      drive(1'b1, 1'b0, 1'b0, 4'h0, 32'h7777_7778);
      chk("R11", "still idle", beat_data_o, 32'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule